// File: doc/BRIEF.md
# Shift-Gain PI Duty Regulator

This block closes the voltage loop of a flyback converter in logic. A control tick arrives from the PWM generator once every 64 switching periods. On each tick the block subtracts an 8-bit sample of the output voltage from an 8-bit digital setpoint. It adds a small proportional term to an integral term and produces an 8-bit duty command for the PWM. The block has no multiplier. Both gains are arithmetic shifts, with one add for the proportional path.

The duty command is clamped to a hard ceiling of 165 counts, which is about 65% of full scale. A soft-start limit holds the command below a ceiling that starts at zero and rises by one count every few ticks, until it reaches 165. The integrator stops moving further into a limit while the output is clamped, so it does not wind up during soft start or overload. A saturation flag shows that the unclamped command fell outside the allowed window.

A small state machine tracks the enable phase:
- ST_OFF: disabled. It moves to ST_RAMP when `en` is high.
- ST_RAMP: the soft-start ceiling is still rising. It moves to ST_RUN when the ceiling reaches 165.
- ST_RUN: the full ceiling is in force.

Any state returns to ST_OFF when `en` is low.

Top module: `flyback_pi_duty`

## Requirements
- R1: After reset `duty` is 0 and `sat` is 0.
- R2: `duty` never exceeds 165. A computed command above the active ceiling is replaced by the ceiling and `sat` is set to 1.
- R3: The error is setpoint minus sample, as a signed 9-bit value. The proportional term is 3 duty counts per error count, built as (error shifted left by 1) plus error.
- R4: The integrator is held with 8 fraction bits below the duty LSB. On each tick it adds error shifted left by 4, which is 1/16 count per error count. The command is floor(integrator / 256) plus the proportional term.
- R5: A command below 0 gives `duty` = 0 and `sat` = 1. A command inside [0, ceiling] gives `duty` equal to the command and `sat` = 0.
- R6: The ceiling is 0 in the first tick after enable. It rises by one count every 4 enabled ticks, until it reaches 165. The value used on a tick is the ceiling from before that tick's step.
- R7: The outputs change only in the cycle after a clock edge where `en` and `tick` are both high. Between ticks they hold.
- R8: The integrator is kept within [0, 165·256]. It is not updated on a tick that saturates high with a positive error, nor on a tick that saturates low with a negative error.
- R9: When `en` is low at a clock edge, in the next cycle `duty` is 0 and `sat` is 0, the integrator is cleared, and soft start restarts from a ceiling of 0.
- R10: The state machine is in ST_RUN only while the ceiling equals 165.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous regulator enable |
| tick | input | 1 | One-cycle control update strobe from the PWM block |
| setpoint | input | 8 | Target output-voltage code |
| vsample | input | 8 | Measured output-voltage code |
| duty | output | 8 | Duty command, 0 to 165 |
| sat | output | 1 | The last computed command was clamped |

## Verification
A held large positive error during soft start shows whether the ceiling staircase is stepped at the correct tick count. The same stimulus shows that the integrator stays frozen: when the error then drops to zero, the command falls to zero instead of staying at a wound-up value. Setpoints with samples close to them (within ±8 counts) mainly exercise the unclamped proportional-plus-integral arithmetic and the fraction truncation. Occasional full-range random samples push the command through both clamps and through the conditional integration rule. Directed cases then check: a strongly negative error; gaps between ticks where the outputs must hold; and disabling in mid-run, which must clear the state and restart the ramp.

// File: rtl/flyback_pi_pkg.sv
package flyback_pi_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAMP = 2'd1,
        ST_RUN  = 2'd2
    } reg_state_e;
endpackage

// File: rtl/pi_gain.sv
module pi_gain #(
    parameter int DW       = 8,
    parameter int ACC_W    = 20,
    parameter int KP_SH0   = 1,
    parameter int KP_SH1   = 0,
    parameter bit KP_ADD   = 1'b1,
    parameter int KI_SH    = 4
) (
    input  logic [DW-1:0]           sp,
    input  logic [DW-1:0]           vs,
    input  logic signed [ACC_W-1:0] integ,
    output logic signed [DW:0]      err,
    output logic signed [ACC_W-1:0] p_term,
    output logic signed [ACC_W-1:0] i_sum
);
    logic signed [ACC_W-1:0] err_x;

    always_comb begin
        err   = $signed({1'b0, sp}) - $signed({1'b0, vs});
        err_x = {{(ACC_W-DW-1){err[DW]}}, err};
        i_sum = integ + (err_x <<< KI_SH);
    end

    generate
        if (KP_ADD) begin : g_kp_two_terms
            always_comb p_term = (err_x <<< KP_SH0) + (err_x <<< KP_SH1);
        end else begin : g_kp_one_term
            always_comb p_term = err_x <<< KP_SH0;
        end
    endgenerate
endmodule

// File: rtl/pi_limit.sv
module pi_limit #(
    parameter int DW       = 8,
    parameter int ACC_W    = 20,
    parameter int FRAC     = 8,
    parameter int DUTY_MAX = 165
) (
    input  logic signed [ACC_W-1:0] i_sum,
    input  logic signed [ACC_W-1:0] p_term,
    input  logic [DW-1:0]           ceil_v,
    output logic signed [ACC_W-1:0] i_clamped,
    output logic [DW-1:0]           duty_v,
    output logic                    sat_hi,
    output logic                    sat_lo
);
    localparam logic signed [ACC_W-1:0] ILIM = ACC_W'(DUTY_MAX * (2 ** FRAC));

    logic signed [ACC_W-1:0] cmd;
    logic signed [ACC_W-1:0] ceil_x;

    always_comb begin
        if (i_sum[ACC_W-1])
            i_clamped = '0;
        else if (i_sum > ILIM)
            i_clamped = ILIM;
        else
            i_clamped = i_sum;

        cmd    = (i_clamped >>> FRAC) + p_term;
        ceil_x = $signed({{(ACC_W-DW){1'b0}}, ceil_v});
        sat_hi = cmd > ceil_x;
        sat_lo = cmd[ACC_W-1];

        if (sat_hi)
            duty_v = ceil_v;
        else if (sat_lo)
            duty_v = '0;
        else
            duty_v = cmd[DW-1:0];
    end
endmodule

// File: rtl/pi_softstart.sv
module pi_softstart #(
    parameter int DW         = 8,
    parameter int DUTY_MAX   = 165,
    parameter int RAMP_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [DW-1:0] ceil_o,
    output logic          at_max
);
    localparam int CW = $clog2(RAMP_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(RAMP_TICKS - 1);
    localparam logic [DW-1:0] MAX_V    = DW'(DUTY_MAX);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] ceil_q;

    assign ceil_o = ceil_q;
    assign at_max = (ceil_q == MAX_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ceil_q <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
            ceil_q <= '0;
        end else if (step && !at_max) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                ceil_q <= ceil_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CEIL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ceil_q <= MAX_V); // R6
    AST_CEIL_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (ceil_q == $past(ceil_q)) || (ceil_q == $past(ceil_q) + 1'b1)); // R6
endmodule

// File: rtl/flyback_pi_duty.sv
module flyback_pi_duty #(
    parameter int DW         = 8,
    parameter int FRAC       = 8,
    parameter int DUTY_MAX   = 165,
    parameter int RAMP_TICKS = 4,
    parameter int KP_SH0     = 1,
    parameter int KP_SH1     = 0,
    parameter bit KP_ADD     = 1'b1,
    parameter int KI_SH      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [DW-1:0] setpoint,
    input  logic [DW-1:0] vsample,
    output logic [DW-1:0] duty,
    output logic          sat
);
    import flyback_pi_pkg::*;

    localparam int ACC_W = DW + FRAC + 4;
    localparam logic [DW-1:0] MAX_V = DW'(DUTY_MAX);
    localparam logic signed [ACC_W-1:0] ILIM = ACC_W'(DUTY_MAX * (2 ** FRAC));

    reg_state_e state_q, state_d;

    logic [DW-1:0]           duty_q;
    logic                    sat_q;
    logic signed [ACC_W-1:0] integ_q;

    logic signed [DW:0]      err;
    logic signed [ACC_W-1:0] p_term, i_sum, i_clamped;
    logic [DW-1:0]           ceil_v, duty_v;
    logic                    sat_hi, sat_lo, at_max;
    logic                    ramp_step, upd, hold_int;

    pi_gain #(
        .DW(DW), .ACC_W(ACC_W), .KP_SH0(KP_SH0), .KP_SH1(KP_SH1),
        .KP_ADD(KP_ADD), .KI_SH(KI_SH)
    ) u_gain (
        .sp(setpoint), .vs(vsample), .integ(integ_q),
        .err(err), .p_term(p_term), .i_sum(i_sum)
    );

    pi_limit #(
        .DW(DW), .ACC_W(ACC_W), .FRAC(FRAC), .DUTY_MAX(DUTY_MAX)
    ) u_limit (
        .i_sum(i_sum), .p_term(p_term), .ceil_v(ceil_v),
        .i_clamped(i_clamped), .duty_v(duty_v), .sat_hi(sat_hi), .sat_lo(sat_lo)
    );

    pi_softstart #(
        .DW(DW), .DUTY_MAX(DUTY_MAX), .RAMP_TICKS(RAMP_TICKS)
    ) u_soft (
        .clk(clk), .rst_n(rst_n), .clear(!en), .step(ramp_step),
        .ceil_o(ceil_v), .at_max(at_max)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state and ramp stepping
    always_comb begin
        state_d   = state_q;
        ramp_step = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                ramp_step = en && tick;
                if (en) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                ramp_step = en && tick;
                if (!en)         state_d = ST_OFF;
                else if (at_max) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign upd      = en && tick;
    assign hold_int = (sat_hi && !err[DW] && (err != '0)) || (sat_lo && err[DW]);

    // outputs and integrator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q  <= '0;
            sat_q   <= 1'b0;
            integ_q <= '0;
        end else if (!en) begin
            duty_q  <= '0;
            sat_q   <= 1'b0;
            integ_q <= '0;
        end else if (upd) begin
            duty_q <= duty_v;
            sat_q  <= sat_hi || sat_lo;
            if (!hold_int) integ_q <= i_clamped;
        end
    end

    assign duty = duty_q;
    assign sat  = sat_q;

    AST_DUTY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q <= MAX_V); // R2
    AST_DUTY_UNDER_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q <= ceil_v); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        en && !tick |=> $stable(duty_q) && $stable(sat_q) && $stable(integ_q)); // R7
    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (duty_q == '0) && !sat_q && (integ_q == '0) && (ceil_v == '0)); // R9
    AST_INTEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !integ_q[ACC_W-1] && (integ_q <= ILIM)); // R8
    AST_RUN_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> at_max); // R10
endmodule

// File: tb/test_flyback_pi_duty.sv
module test_flyback_pi_duty;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] setpoint = '0;
    logic [7:0] vsample = '0;
    logic [7:0] duty;
    logic       sat;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_int = 0, m_ceil = 0, m_cnt = 0;
    int exp_duty = 0, exp_sat = 0;

    localparam int MAXD = 165;
    localparam int ILIM = 165 * 256;

    always #4 clk = ~clk;

    flyback_pi_duty i_flyback_pi_duty (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .setpoint(setpoint), .vsample(vsample), .duty(duty), .sat(sat)
    );

    task automatic check(input string tag);
        checks++;
        if (duty !== 8'(exp_duty) || sat !== 1'(exp_sat)) begin
            errors++;
            $display("FAIL %s: duty=%0d sat=%0d expected duty=%0d sat=%0d",
                     tag, duty, sat, exp_duty, exp_sat);
        end
    endtask

    // reference model from R3..R6, R8
    task automatic model_tick(input int s, input int v);
        int e, p, ic, cmd;
        e  = s - v;
        p  = 3 * e;
        ic = m_int + e * 16;
        if (ic < 0) ic = 0;
        if (ic > ILIM) ic = ILIM;
        cmd = ic / 256 + p;
        if (cmd > m_ceil) begin
            exp_duty = m_ceil; exp_sat = 1;
            if (e <= 0) m_int = ic;
        end else if (cmd < 0) begin
            exp_duty = 0; exp_sat = 1;
            if (e >= 0) m_int = ic;
        end else begin
            exp_duty = cmd; exp_sat = 0;
            m_int = ic;
        end
        if (m_ceil < MAXD) begin
            m_cnt++;
            if (m_cnt == 4) begin
                m_cnt = 0;
                m_ceil++;
            end
        end
    endtask

    // called at a negedge; returns at a negedge after checking
    task automatic do_tick(input int s, input int v, input string tag);
        setpoint = 8'(s);
        vsample  = 8'(v);
        tick     = 1'b1;
        @(posedge clk);
        model_tick(s, v);
        @(negedge clk);
        tick = 1'b0;
        check(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            setpoint = 8'($urandom_range(0, 255));
            vsample  = 8'($urandom_range(0, 255));
            @(negedge clk);
        end
        check(tag);
    endtask

    task automatic disable_now();
        en = 1'b0;
        @(negedge clk);
        m_int = 0; m_ceil = 0; m_cnt = 0;
        exp_duty = 0; exp_sat = 0;
        check("R9 disable clears");
        en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: duty=%0d sat=%0d expected run to end", duty, sat);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        exp_duty = 0; exp_sat = 0;
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");
        en = 1'b1;

        // soft start with large positive error: duty follows ceiling staircase
        for (int k = 0; k < 4 * MAXD + 12; k++)
            do_tick(200, 0, "R6 ramp");
        check("R2 ceiling 165");
        do_tick(255, 0, "R2 clamp at max");

        // anti-windup: integrator held at 0, error zero gives duty 0
        do_tick(120, 120, "R8 no windup");

        // hold between ticks
        do_tick(130, 125, "R3 proportional");
        idle(5, "R7 hold between ticks");

        // negative error clamps low
        do_tick(0, 255, "R5 low clamp");

        // random mix near setpoint plus occasional wide swings
        for (int k = 0; k < 3000; k++) begin
            int s, v;
            s = $urandom_range(20, 230);
            if ($urandom_range(0, 7) == 0) v = $urandom_range(0, 255);
            else v = s + $urandom_range(0, 16) - 8;
            do_tick(s, v, "R4 random PI");
            if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3), "R7 random gap");
        end

        // disable mid-run, then restart ramp
        disable_now();
        do_tick(200, 100, "R6 restart ceiling 0");
        for (int k = 0; k < 10; k++) do_tick(200, 100, "R6 restart ramp");
        disable_now();
        do_tick(100, 100, "R9 integrator cleared");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule